// File: doc/BRIEF.md
# Serial Converter Command and Result Port

This block is the device-side digital front end of a multichannel successive-approximation converter. A host selects the device with an active-low chip select and drives a serial clock. On each transfer the host shifts in an 8-bit command word, most significant bit first. At the same time the block shifts out the result of the previous conversion on a serial output that has its own drive-enable for a tri-state pad.

The command chooses four things: the analog channel, the transfer length of the next exchange, the order of the output bits, and the output coding. The block gives the analog side a 4-bit channel address and a sample-window signal. On the last falling clock edge of a transfer it sends a one-cycle start pulse to the converter and pulls end-of-conversion low. A fixed number of system clocks later it latches the converter's result word and raises end-of-conversion again.

The chip select, serial clock and serial data are synchronized into the system clock domain. Edges are detected there, so every pin change takes effect on the third system clock edge after it.

Top module: `adc_serial_link`

## Requirements
- R1: After reset, eoc_o is 1, sdo_en_o is 0, sdo_o is 0, sample_o is 0, conv_start_o is 0 and chan_o is 0. The held format is 12 clocks, MSB first, unipolar, and the held result is 0.
- R2: While cs_ni is high, sdo_en_o and sdo_o are 0. Edges on sclk_i and sdi_i then change neither chan_o, sample_o nor eoc_o, and cause no conv_start_o pulse.
- R3: A falling edge on cs_ni restarts the bit counters and sets sdo_en_o. It puts the first bit of the formatted previous result on sdo_o before any sclk_i edge.
- R4: The command is taken from sdi_i on the first 8 rising sclk_i edges, most significant bit first. Bits [7:4] are the channel. Bits [3:2] are the length code. Bit 1 set means LSB-first. Bit 0 set means bipolar. Later rising edges in the same transfer are not captured.
- R5: chan_o takes command bits [7:4] after the 4th rising sclk_i edge and keeps its old value before that edge.
- R6: A transfer lasts N falling edges. N is 8 for length code 01, 16 for code 11, and 12 for codes 00 and 10. The code used is the one captured in the previous complete transfer.
- R7: With result r and output code v, the output frame is W = {v, 4'b0} (16 bits), and a transfer sends the top N bits W[15:16-N]. MSB-first order sends W[15] down to W[16-N]. LSB-first order sends W[16-N] up to W[15]. sdo_o moves to the next bit on each falling sclk_i edge.
- R8: Unipolar mode sends v = r. Bipolar mode sends v = r with bit 11 inverted.
- R9: sample_o rises after the 4th falling sclk_i edge and falls after the Nth.
- R10: On the Nth falling edge, conv_start_o pulses for one cycle and eoc_o goes low. eoc_o stays low for exactly CONV_CYCLES system clocks, then rises. The value of conv_result_i at that moment becomes the result sent in the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, asynchronous to clk_i |
| sclk_i | input | 1 | Serial clock, idles low |
| sdi_i | input | 1 | Serial command data |
| conv_result_i | input | 12 | Result word from the converter core |
| sdo_o | output | 1 | Serial result data |
| sdo_en_o | output | 1 | Drive enable for the sdo pad; 0 means high impedance |
| eoc_o | output | 1 | End of conversion; low while converting |
| chan_o | output | 4 | Channel address for the analog multiplexer |
| sample_o | output | 1 | Sample window for the capacitor array |
| conv_start_o | output | 1 | One-cycle conversion start pulse |

## Verification
Each pin change shows at the outputs three system clock edges later: two synchronizer stages plus one edge-detect register. The bench therefore changes an input on a falling system clock edge and samples six clock cycles later, before it drives the next change. This covers sdo_o and sdo_en_o after a chip-select edge, chan_o after a rising serial edge, and sdo_o and sample_o after a falling one. The low time of eoc_o and the number of start pulses are counted cycle by cycle by a monitor on every falling clock edge, and compared with CONV_CYCLES and one once eoc_o has risen again.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;
  localparam int RES_W   = 12;
  localparam int FRAME_W = 16;
  localparam int CMD_W   = 8;
  localparam int CHAN_W  = 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [1:0] len;
    logic       lsb_first;
    logic       bipolar;
  } fmt_t;

  function automatic logic [CNT_W-1:0] len_clocks(logic [1:0] code);
    case (code)
      2'b01:   return CNT_W'(8);
      2'b11:   return CNT_W'(16);
      default: return CNT_W'(12);
    endcase
  endfunction
endpackage

// File: rtl/adc_bit_sync.sv
module adc_bit_sync #(
  parameter int         W      = 3,
  parameter int         STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/adc_cmd_ctrl.sv
module adc_cmd_ctrl
  import adc_if_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_high_i,
  input  logic              cs_fall_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sdi_i,
  output logic [CHAN_W-1:0] chan_o,
  output logic              sample_o,
  output logic              shift_o,
  output logic              last_o,
  output logic              conv_start_o,
  output fmt_t              fmt_o
);
  logic [CMD_W-1:0]  cmd_sr;
  logic [CNT_W-1:0]  rise_cnt, fall_cnt, n_len;
  logic [CHAN_W-1:0] chan_q;
  logic              sample_q, start_q;
  fmt_t              fmt_q;
  logic              active, rise_ok, fall_ok, last;

  assign active  = !cs_high_i && !cs_fall_i;
  assign n_len   = len_clocks(fmt_q.len);
  assign rise_ok = active && rise_i && (rise_cnt < CNT_W'(CMD_W));
  assign fall_ok = active && fall_i && (fall_cnt < n_len);
  assign last    = fall_ok && (CNT_W'(fall_cnt + 1'b1) == n_len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_sr   <= '0;
      rise_cnt <= '0;
      fall_cnt <= '0;
      chan_q   <= '0;
      sample_q <= 1'b0;
      start_q  <= 1'b0;
      fmt_q    <= '0;
    end else begin
      start_q <= last;
      if (cs_fall_i) begin
        rise_cnt <= '0;
        fall_cnt <= '0;
        sample_q <= 1'b0;
      end else if (cs_high_i) begin
        sample_q <= 1'b0;
      end else begin
        if (rise_ok) begin
          cmd_sr   <= {cmd_sr[CMD_W-2:0], sdi_i};
          rise_cnt <= rise_cnt + 1'b1;
          if (rise_cnt == CNT_W'(CHAN_W - 1))
            chan_q <= {cmd_sr[CHAN_W-2:0], sdi_i};
        end
        if (fall_ok) begin
          fall_cnt <= fall_cnt + 1'b1;
          if (fall_cnt == CNT_W'(3)) sample_q <= 1'b1;
          if (last) begin
            sample_q <= 1'b0;
            fmt_q    <= fmt_t'(cmd_sr[3:0]);
          end
        end
      end
    end
  end

  assign chan_o       = chan_q;
  assign sample_o     = sample_q;
  assign shift_o      = fall_ok;
  assign last_o       = last;
  assign conv_start_o = start_q;
  assign fmt_o        = fmt_q;

  // R4: never more than the command width captured per transfer
  assert_cmd_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_cnt <= CNT_W'(CMD_W));
  // R2: no sample window while deselected
  assert_no_sample_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_high_i |=> !sample_q);
  // R10: conversion starts exactly as the sample window closes
  assert_start_closes_window_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> (!sample_q && $past(sample_q)));
endmodule

// File: rtl/adc_out_shift.sv
module adc_out_shift
  import adc_if_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  fmt_t             fmt_i,
  input  logic [RES_W-1:0] result_i,
  output logic             sdo_o
);
  logic [FRAME_W-1:0] sr_q, word, rev, frame;
  logic [RES_W-1:0]   code;
  logic [CNT_W-1:0]   n_len;

  always_comb begin
    code = result_i;
    if (fmt_i.bipolar) code[RES_W-1] = ~result_i[RES_W-1];
    word  = {code, {(FRAME_W-RES_W){1'b0}}};
    n_len = len_clocks(fmt_i.len);
    for (int i = 0; i < FRAME_W; i++) rev[i] = word[FRAME_W-1-i];
    // LSB-first: shift the reversed window so its first bit sits on top
    frame = fmt_i.lsb_first ? (rev << (CNT_W'(FRAME_W) - n_len)) : word;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= frame;
    else if (shift_i) sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
  end

  assign sdo_o = sr_q[FRAME_W-1];

  // R7: output bit only moves on a load or a falling serial edge
  assert_sdo_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(sdo_o));
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_if_pkg::*;
#(
  parameter int CONV_CYCLES = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [RES_W-1:0] result_i,
  output logic             eoc_o,
  output logic [RES_W-1:0] result_o
);
  localparam int CW = $clog2(CONV_CYCLES + 1);

  logic [CW-1:0]    cnt_q;
  logic             eoc_q;
  logic [RES_W-1:0] res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      eoc_q <= 1'b1;
      res_q <= '0;
    end else if (eoc_q) begin
      if (start_i) begin
        eoc_q <= 1'b0;
        cnt_q <= CW'(CONV_CYCLES - 1);
      end
    end else if (cnt_q == '0) begin
      eoc_q <= 1'b1;
      res_q <= result_i;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign eoc_o    = eoc_q;
  assign result_o = res_q;

  // R10: a start drops end-of-conversion on the next edge
  assert_eoc_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && eoc_q) |=> !eoc_q);
  // R10: result held and busy kept until the count runs out
  assert_eoc_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eoc_q && cnt_q != '0) |=> (!eoc_q && $stable(res_q)));
endmodule

// File: rtl/adc_serial_link.sv
module adc_serial_link
  import adc_if_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CONV_CYCLES = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [RES_W-1:0]  conv_result_i,
  output logic              sdo_o,
  output logic              sdo_en_o,
  output logic              eoc_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic              sample_o,
  output logic              conv_start_o
);
  logic [2:0]       sync_q;
  logic             cs_s, sclk_s, sdi_s, cs_d, sclk_d;
  logic             cs_fall, rise, fall, sdo_en_q;
  logic             shift, last, sdo_bit;
  fmt_t             fmt;
  logic [RES_W-1:0] result;

  adc_bit_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
    .clk_i, .rst_ni,
    .d_i ({cs_ni, sclk_i, sdi_i}),
    .q_o (sync_q)
  );
  assign {cs_s, sclk_s, sdi_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d     <= 1'b1;
      sclk_d   <= 1'b0;
      sdo_en_q <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
      if (cs_s)         sdo_en_q <= 1'b0;
      else if (cs_fall) sdo_en_q <= 1'b1;
    end
  end

  assign cs_fall = cs_d & ~cs_s;
  assign rise    = sclk_s & ~sclk_d;
  assign fall    = ~sclk_s & sclk_d;

  adc_cmd_ctrl i_ctrl (
    .clk_i, .rst_ni,
    .cs_high_i   (cs_s),
    .cs_fall_i   (cs_fall),
    .rise_i      (rise),
    .fall_i      (fall),
    .sdi_i       (sdi_s),
    .chan_o      (chan_o),
    .sample_o    (sample_o),
    .shift_o     (shift),
    .last_o      (last),
    .conv_start_o(conv_start_o),
    .fmt_o       (fmt)
  );

  adc_out_shift i_out (
    .clk_i, .rst_ni,
    .load_i  (cs_fall),
    .shift_i (shift),
    .fmt_i   (fmt),
    .result_i(result),
    .sdo_o   (sdo_bit)
  );

  adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) i_timer (
    .clk_i, .rst_ni,
    .start_i (last),
    .result_i(conv_result_i),
    .eoc_o   (eoc_o),
    .result_o(result)
  );

  assign sdo_en_o = sdo_en_q;
  assign sdo_o    = sdo_en_q & sdo_bit;
endmodule

// File: tb/test_adc_serial_link.sv
`timescale 1ns/1ps
module test_adc_serial_link;
  localparam int CONV = 20;
  localparam int HOLD = 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, sclk_i = 1'b0, sdi_i = 1'b0;
  logic [11:0] conv_result_i = '0;
  logic        sdo_o, sdo_en_o, eoc_o, sample_o, conv_start_o;
  logic [3:0]  chan_o;

  int n_chk = 0, n_bad = 0;
  int eoc_low_cnt = 0, start_cnt = 0;
  bit done = 0;

  // bench model of held state
  logic [11:0] m_res = '0;
  logic [1:0]  m_len = 2'b00;
  bit          m_lsb = 0, m_bip = 0;
  logic [3:0]  m_chan = '0;

  always #2 clk = ~clk;

  adc_serial_link #(.SYNC_STAGES(2), .CONV_CYCLES(CONV)) i_adc_serial_link (
    .clk_i(clk), .rst_ni, .cs_ni, .sclk_i, .sdi_i, .conv_result_i,
    .sdo_o, .sdo_en_o, .eoc_o, .chan_o, .sample_o, .conv_start_o
  );

  always @(negedge clk) begin
    if (rst_ni && !eoc_o) eoc_low_cnt++;
    if (rst_ni && conv_start_o) start_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic int clocks(logic [1:0] code);
    return (code == 2'b01) ? 8 : (code == 2'b11) ? 16 : 12;
  endfunction

  function automatic bit exp_bit(logic [11:0] res, logic [1:0] len, bit lsb, bit bip, int k);
    int n;
    logic [11:0] v;
    logic [15:0] w;
    n = clocks(len);
    v = res;
    if (bip) v[11] = ~v[11];
    w = {v, 4'b0};
    return lsb ? w[16-n+k] : w[15-k];
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [11:0] next_res);
    int n;
    int guard;
    string tag;
    n   = clocks(m_len);
    tag = m_bip ? "R8" : "R7";
    conv_result_i = next_res;
    eoc_low_cnt = 0;
    start_cnt   = 0;
    cs_ni = 1'b0;
    wait_clk(HOLD);
    chk(sdo_en_o == 1'b1, "R3", sdo_en_o, 1);
    chk(sdo_o == exp_bit(m_res, m_len, m_lsb, m_bip, 0), "R3", sdo_o,
        exp_bit(m_res, m_len, m_lsb, m_bip, 0));
    for (int k = 0; k < n; k++) begin
      sdi_i  = (k < 8) ? cmd[7-k] : $urandom_range(1);  // R4: bits past 8 ignored
      sclk_i = 1'b1;
      wait_clk(HOLD);
      if (k < 3) chk(chan_o == m_chan, "R5", chan_o, m_chan);
      if (k == 3) chk(chan_o == cmd[7:4], "R5", chan_o, cmd[7:4]);
      sclk_i = 1'b0;
      wait_clk(HOLD);
      if (k + 1 < n)
        chk(sdo_o == exp_bit(m_res, m_len, m_lsb, m_bip, k + 1), tag, sdo_o,
            exp_bit(m_res, m_len, m_lsb, m_bip, k + 1));
      chk(sample_o == ((k + 1 >= 4) && (k + 1 < n)), "R9", sample_o,
          int'((k + 1 >= 4) && (k + 1 < n)));
      if (k == n - 2) chk(eoc_o == 1'b1, "R6", eoc_o, 1);
    end
    chk(eoc_o == 1'b0, "R6", eoc_o, 0);
    chk(chan_o == cmd[7:4], "R4", chan_o, cmd[7:4]);
    guard = 0;
    while (!eoc_o && guard < 1000) begin
      wait_clk(1);
      guard++;
    end
    conv_result_i = 12'($urandom);  // must not reach the held result
    chk(eoc_low_cnt == CONV, "R10", eoc_low_cnt, CONV);
    chk(start_cnt == 1, "R10", start_cnt, 1);
    cs_ni = 1'b1;
    wait_clk(HOLD);
    chk(sdo_en_o == 1'b0 && sdo_o == 1'b0, "R2", {sdo_en_o, sdo_o}, 0);
    m_res  = next_res;
    m_len  = cmd[3:2];
    m_lsb  = cmd[1];
    m_bip  = cmd[0];
    m_chan = cmd[7:4];
  endtask

  task automatic idle_noise();
    start_cnt = 0;
    for (int i = 0; i < 10; i++) begin
      sdi_i  = $urandom_range(1);
      sclk_i = ~sclk_i;
      wait_clk(HOLD);
    end
    sclk_i = 1'b0;
    wait_clk(HOLD);
    chk(chan_o == m_chan, "R2", chan_o, m_chan);
    chk(sample_o == 1'b0 && eoc_o == 1'b1, "R2", {sample_o, eoc_o}, 1);
    chk(start_cnt == 0, "R2", start_cnt, 0);
    chk(sdo_en_o == 1'b0, "R2", sdo_en_o, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0a7c));
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(HOLD);
    chk(eoc_o == 1'b1, "R1", eoc_o, 1);
    chk(sdo_en_o == 1'b0 && sdo_o == 1'b0, "R1", {sdo_en_o, sdo_o}, 0);
    chk(sample_o == 1'b0 && conv_start_o == 1'b0, "R1", {sample_o, conv_start_o}, 0);
    chk(chan_o == 4'h0, "R1", chan_o, 0);
    // directed: every length code, both orders, both codings
    xfer(8'b1010_01_0_0, 12'hA5C);
    xfer(8'b0011_11_1_0, 12'h801);
    xfer(8'b1111_10_0_1, 12'h7F3);
    xfer(8'b0100_00_1_1, 12'h000);
    xfer(8'b0001_01_1_1, 12'hFFF);
    xfer(8'b0110_11_0_1, 12'h123);
    idle_noise();
    xfer(8'b1001_01_0_0, 12'h9E4);
    for (int t = 0; t < 40; t++) begin
      xfer(8'($urandom), 12'($urandom));
      if (t % 10 == 0) idle_noise();
    end
    done = 1;
    report();
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      report();
    end
  end
endmodule